// File: doc/BRIEF.md
# Dual-Channel Compare Reference Generator

This block turns the results of comparing a shared up/down counter against two compare values into two per-channel reference waveforms. It also produces a third, combined reference that belongs to the first channel.

The counter value, its count direction, an update pulse and a trigger pulse all arrive from outside. Each channel has its own compare value and its own 4-bit mode code. The supported behaviours are:

- the basic match and level modes;
- trigger-gated retriggerable one-pulse modes;
- combined and asymmetric modes, in which the first channel's merged output mixes both channel references.

Every reference is registered. It reflects the inputs sampled on the previous rising clock edge.

Top module: `tim_oc_refgen`

## Requirements
- R1: While rst_n is low, ref_a, ref_b and ref_mix are 0. After reset, each output takes the value computed from the inputs present at a rising edge, one clock later.
- R2: Mode code 4 drives a channel's reference to 0, and mode code 5 drives it to 1, regardless of counter, compare, trigger or update.
- R3: Mode code 0 and the unused codes 14 and 15 hold the channel's reference at its previous value.
- R4: Codes 1, 2 and 3 act only in a cycle where the counter equals the channel's compare value. In that cycle, code 1 sets the reference to 1, code 2 clears it to 0 and code 3 inverts it. In other cycles the reference holds.
- R5: Code 6 is level PWM. Counting up (dir_down=0), the reference is 1 when cnt < compare. Counting down, it is 1 when cnt <= compare. Code 7 gives the exact inverse of code 6.
- R6: Each channel keeps a gate flag. A trigger pulse sets it and an update pulse clears it. If both pulses come in the same cycle, the trigger wins. The flag takes effect in the same cycle as the pulse that sets it. A trigger that arrives while the flag is already set changes nothing.
- R7: Code 8, counting up: the reference is 1 while the gate is clear, and follows code 6 while it is set. Code 8, counting down: the reference is 0 while the gate is clear, and follows code 6 while it is set.
- R8: Code 9, counting up: the reference is 0 while the gate is clear, and follows code 7 while it is set. Code 9, counting down: the reference is 1 while the gate is clear, and follows code 6 while it is set.
- R9: Codes 10 and 12 make a channel's reference behave as code 6. Codes 11 and 13 make it behave as code 7.
- R10: With mode_a at 10, ref_mix is ref_a OR ref_b. With mode_a at 11, ref_mix is ref_a AND ref_b.
- R11: With mode_a at 12 or 13, ref_mix equals ref_a in cycles computed while counting up, and ref_b in cycles computed while counting down.
- R12: For any other mode_a, ref_mix equals ref_a. mode_b affects only ref_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CW | Shared counter value |
| dir_down | input | 1 | 1 when the counter is counting down |
| upd | input | 1 | Update event pulse |
| trig | input | 1 | Trigger event pulse |
| cmp_a | input | CW | Compare value of channel A |
| cmp_b | input | CW | Compare value of channel B |
| mode_a | input | 4 | Mode code of channel A |
| mode_b | input | 4 | Mode code of channel B |
| ref_a | output | 1 | Channel A reference |
| ref_b | output | 1 | Channel B reference |
| ref_mix | output | 1 | Combined reference of channel A |

## Verification
A wrong gate flag shows up one clock later. A one-pulse reference then sits at its idle level after a trigger, or keeps comparing after an update, so the gate is exercised through the trigger, update and retrigger sequences. A stale held reference stays hidden while a level mode is running. It only shows up when the channel moves to a hold or toggle code, so the bench follows force codes with frozen, match and toggle codes. The merged output is checked against both channel references in both count directions.

// File: rtl/tim_oc_refgen.sv
module tim_oc_refgen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          dir_down,
  input  logic          upd,
  input  logic          trig,
  input  logic [CW-1:0] cmp_a,
  input  logic [CW-1:0] cmp_b,
  input  logic [3:0]    mode_a,
  input  logic [3:0]    mode_b,
  output logic          ref_a,
  output logic          ref_b,
  output logic          ref_mix
);

  localparam logic [3:0] M_HOLD = 4'd0,  M_SETM = 4'd1,  M_CLRM = 4'd2,  M_TOGM = 4'd3;
  localparam logic [3:0] M_LO   = 4'd4,  M_HI   = 4'd5,  M_PWM1 = 4'd6,  M_PWM2 = 4'd7;
  localparam logic [3:0] M_OPM1 = 4'd8,  M_OPM2 = 4'd9,  M_CMB1 = 4'd10, M_CMB2 = 4'd11;
  localparam logic [3:0] M_ASY1 = 4'd12, M_ASY2 = 4'd13;
  localparam int NCH = 2;

  function automatic logic pwm_lvl(logic [CW-1:0] c, logic [CW-1:0] k, logic dn, logic inv);
    logic lvl;
    lvl = dn ? (c <= k) : (c < k);
    return lvl ^ inv;
  endfunction

  function automatic logic ref_next(logic [3:0] m, logic [CW-1:0] c, logic [CW-1:0] k,
                                    logic dn, logic gate, logic cur);
    logic hit;
    hit = (c == k);
    case (m)
      M_SETM:         return hit ? 1'b1 : cur;
      M_CLRM:         return hit ? 1'b0 : cur;
      M_TOGM:         return cur ^ hit;
      M_LO:           return 1'b0;
      M_HI:           return 1'b1;
      M_PWM1, M_CMB1, M_ASY1: return pwm_lvl(c, k, dn, 1'b0);
      M_PWM2, M_CMB2, M_ASY2: return pwm_lvl(c, k, dn, 1'b1);
      M_OPM1:         return gate ? pwm_lvl(c, k, dn, 1'b0) : !dn;
      M_OPM2:         return gate ? pwm_lvl(c, k, dn, !dn) : dn;
      default:        return cur;
    endcase
  endfunction

  logic [CW-1:0] cmp_v  [NCH];
  logic [3:0]    mode_v [NCH];
  logic [NCH-1:0] ref_q, ref_d;

  assign cmp_v[0]  = cmp_a;
  assign cmp_v[1]  = cmp_b;
  assign mode_v[0] = mode_a;
  assign mode_v[1] = mode_b;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic gate_q, gate_d, r_q;
    assign gate_d   = trig | (gate_q & ~upd);
    assign ref_d[i] = ref_next(mode_v[i], cnt, cmp_v[i], dir_down, gate_d, r_q);
    assign ref_q[i] = r_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gate_q <= 1'b0;
        r_q    <= 1'b0;
      end else begin
        gate_q <= gate_d;
        r_q    <= ref_d[i];
      end
    end
  end

  logic mix_d, mix_q;
  always_comb begin
    case (mode_a)
      M_CMB1:         mix_d = ref_d[0] | ref_d[1];
      M_CMB2:         mix_d = ref_d[0] & ref_d[1];
      M_ASY1, M_ASY2: mix_d = dir_down ? ref_d[1] : ref_d[0];
      default:        mix_d = ref_d[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mix_q <= 1'b0;
    else        mix_q <= mix_d;
  end

  assign ref_a   = ref_q[0];
  assign ref_b   = ref_q[1];
  assign ref_mix = mix_q;

  a_r2_force_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == M_HI) |=> ref_a);
  a_r2_force_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b == M_LO) |=> !ref_b);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == M_HOLD) |=> $stable(ref_a));
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == M_TOGM && cnt == cmp_a) |=> (ref_a != $past(ref_a)));
  a_r10_or: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == M_CMB1) |=> (ref_mix == (ref_a | ref_b)));
  a_r10_and: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == M_CMB2) |=> (ref_mix == (ref_a & ref_b)));
  a_r11_asym_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == M_ASY1 && !dir_down) |=> (ref_mix == ref_a));

endmodule

// File: tb/tim_oc_refgen_test.sv
module tim_oc_refgen_test;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt = '0, cmp_a = '0, cmp_b = '0;
  logic dir_down = 1'b0, upd = 1'b0, trig = 1'b0;
  logic [3:0] mode_a = 4'd0, mode_b = 4'd0;
  logic ref_a, ref_b, ref_mix;

  always #10 clk = ~clk;

  tim_oc_refgen #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .dir_down(dir_down), .upd(upd), .trig(trig),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .mode_a(mode_a), .mode_b(mode_b),
    .ref_a(ref_a), .ref_b(ref_b), .ref_mix(ref_mix));

  typedef struct { logic ea, eb, em; string tag; } exp_t;
  exp_t sb[$];
  int n_run = 0, n_fail = 0;
  logic m_a = 0, m_b = 0, g_a = 0, g_b = 0;

  // Reference model written from the requirement text
  function automatic logic lvl(logic [CW-1:0] c, logic [CW-1:0] k, logic dn, logic inv);
    return (dn ? (c <= k) : (c < k)) ^ inv;       // R5
  endfunction

  function automatic logic model(logic [3:0] m, logic [CW-1:0] c, logic [CW-1:0] k,
                                 logic dn, logic g, logic cur);
    case (m)
      4'd1: return (c == k) ? 1'b1 : cur;          // R4
      4'd2: return (c == k) ? 1'b0 : cur;
      4'd3: return (c == k) ? !cur : cur;
      4'd4: return 1'b0;                           // R2
      4'd5: return 1'b1;
      4'd6, 4'd10, 4'd12: return lvl(c, k, dn, 0); // R9
      4'd7, 4'd11, 4'd13: return lvl(c, k, dn, 1);
      4'd8: return dn ? (g ? lvl(c, k, 1, 0) : 1'b0) : (g ? lvl(c, k, 0, 0) : 1'b1); // R7
      4'd9: return dn ? (g ? lvl(c, k, 1, 0) : 1'b1) : (g ? lvl(c, k, 0, 1) : 1'b0); // R8
      default: return cur;                         // R3
    endcase
  endfunction

  task automatic step(input logic [3:0] ma, input logic [3:0] mb, input int c, input int ka,
                      input int kb, input logic dn, input logic tg, input logic up, input string tag);
    exp_t e;
    @(negedge clk);
    mode_a = ma; mode_b = mb; cnt = CW'(c); cmp_a = CW'(ka); cmp_b = CW'(kb);
    dir_down = dn; trig = tg; upd = up;
    g_a = tg ? 1'b1 : (up ? 1'b0 : g_a);           // R6
    g_b = tg ? 1'b1 : (up ? 1'b0 : g_b);
    m_a = model(ma, CW'(c), CW'(ka), dn, g_a, m_a);
    m_b = model(mb, CW'(c), CW'(kb), dn, g_b, m_b);
    e.ea = m_a; e.eb = m_b; e.tag = tag;
    case (ma)
      4'd10: e.em = m_a | m_b;                     // R10
      4'd11: e.em = m_a & m_b;
      4'd12, 4'd13: e.em = dn ? m_b : m_a;         // R11
      default: e.em = m_a;                         // R12
    endcase
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_run++;
      if ({ref_a, ref_b, ref_mix} !== {e.ea, e.eb, e.em}) begin
        n_fail++;
        $display("FAIL %s: got a/b/mix=%b%b%b expected %b%b%b", e.tag,
                 ref_a, ref_b, ref_mix, e.ea, e.eb, e.em);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if ({ref_a, ref_b, ref_mix} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 reset: got %b%b%b expected 000", ref_a, ref_b, ref_mix);
    end
    @(negedge clk); rst_n = 1'b1;

    step(4'd5, 4'd4, 3, 9, 9, 0, 0, 0, "R2 force");
    step(4'd4, 4'd5, 3, 9, 9, 0, 0, 0, "R2 force swap");
    step(4'd5, 4'd5, 3, 9, 9, 0, 0, 0, "R2 force hi");
    step(4'd0, 4'd14, 0, 0, 0, 1, 1, 1, "R3 hold");
    step(4'd15, 4'd0, 200, 2, 5, 0, 0, 0, "R3 hold unused");
    step(4'd4, 4'd4, 0, 0, 0, 0, 0, 0, "R2 clear");
    step(4'd1, 4'd3, 4, 5, 5, 0, 0, 0, "R4 no match");
    step(4'd1, 4'd3, 5, 5, 5, 0, 0, 0, "R4 match set/toggle");
    step(4'd3, 4'd2, 5, 5, 5, 0, 0, 0, "R4 toggle/clear");
    step(4'd3, 4'd3, 6, 5, 5, 0, 0, 0, "R4 toggle no match");
    for (int i = 0; i < 8; i++) step(4'd6, 4'd7, i, 4, 4, 0, 0, 0, "R5 up");
    for (int i = 7; i >= 0; i--) step(4'd6, 4'd7, i, 4, 4, 1, 0, 0, "R5 down");
    step(4'd6, 4'd6, 0, 0, 255, 0, 0, 0, "R5 edges");
    step(4'd6, 4'd6, 255, 0, 255, 1, 0, 0, "R5 edges down");
    // one-pulse, counting up: gate set by trigger, cleared by update
    step(4'd8, 4'd9, 6, 4, 4, 0, 0, 1, "R7 idle up");
    step(4'd8, 4'd9, 2, 4, 4, 0, 0, 0, "R7 idle up");
    step(4'd8, 4'd9, 6, 4, 4, 0, 1, 0, "R6 trigger");
    step(4'd8, 4'd9, 2, 4, 4, 0, 0, 0, "R7 gated");
    step(4'd8, 4'd9, 5, 4, 4, 0, 1, 0, "R6 retrigger");
    step(4'd8, 4'd9, 5, 4, 4, 0, 0, 1, "R6 update clears");
    step(4'd8, 4'd9, 6, 4, 4, 0, 1, 1, "R6 trigger wins");
    step(4'd8, 4'd9, 6, 4, 4, 0, 0, 1, "R6 cleared");
    // one-pulse, counting down
    step(4'd8, 4'd9, 2, 4, 4, 1, 0, 0, "R8 idle down");
    step(4'd8, 4'd9, 2, 4, 4, 1, 1, 0, "R8 trig down");
    step(4'd8, 4'd9, 6, 4, 4, 1, 0, 0, "R7 gated down");
    step(4'd8, 4'd9, 4, 4, 4, 1, 0, 1, "R8 upd down");
    // combined and asymmetric
    for (int i = 0; i < 8; i++) step(4'd10, 4'd6, i, 2, 5, i[0], 0, 0, "R10 or");
    for (int i = 0; i < 8; i++) step(4'd11, 4'd7, i, 6, 2, i[1], 0, 0, "R10 and");
    for (int i = 0; i < 8; i++) step(4'd12, 4'd6, i, 3, 5, i[0], 0, 0, "R11 asym1");
    for (int i = 0; i < 8; i++) step(4'd13, 4'd6, i, 3, 5, i[1], 0, 0, "R11 asym2");
    step(4'd6, 4'd5, 5, 3, 0, 1, 0, 0, "R12 mix follows a");
    step(4'd4, 4'd6, 1, 3, 5, 0, 0, 0, "R12 mix follows a");
    repeat (3) @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule